// File: doc/BRIEF.md
# Receive Buffer Element Writer

This block takes the byte stream of incoming fabric frames that an upstream classifier has already steered to one of two buffer partitions (data or control). When a frame starts it claims the lowest-numbered free buffer element of that partition. It then writes the frame's payload into that element from offset zero, one byte per accepted input byte, through a write port that drives the external element storage.

While the frame passes, the block builds a status word. The word holds the frame type, the reserved and private flags, the declared payload length, the four bytes that follow the two-byte header, and a length-error flag. When the frame closes, the element number, the partition and the status word go into a small first-in-first-out full-element list. A consumer reads entries from the head of that list and later hands each element back through a free strobe.

If a frame cannot be placed, it is dropped whole and a sticky overflow flag is raised. This happens when its partition has no free element, or when the full-element list could not take the entry the frame will produce. A frame that is cut short by a new start-of-frame is closed with the length-error flag set. A frame whose declared length exceeds the configured element size is also flagged, and its excess bytes are not written.

Top module: `rx_elem_writer`

## Requirements
- R1: After reset every element of both partitions is free, the full-element list is empty, no write is issued and the overflow flag is low.
- R2: A start-of-frame byte (in_sof_i with in_vld_i) claims the lowest-numbered free element of the partition given by in_part_i (0 data, 1 control).
- R3: Frame layout, byte by byte: byte 0 carries type in bits 3:0, the reserved flag in bit 4 and the private flag in bit 5; byte 1 is the payload length (0 to 255); the next four bytes are captured most significant first as the extension word; then come the payload bytes and two vertical-parity bytes.
- R4: Each payload byte is written to the claimed element at offsets 0, 1, 2 … in the same cycle it is presented. Header, extension and parity bytes are never written.
- R5: On the second parity byte the element is closed. From the next cycle an entry appears on the list with this layout: bit 50 partition, bits 49:47 element, bit 46 length error, bit 45 private, bit 44 reserved, bits 43:40 type, bits 39:32 length, bits 31:0 extension word.
- R6: A start-of-frame arriving while a frame is still open closes that frame's element with the length-error bit set, and starts the new frame in the same cycle.
- R7: elem_sz_i selects the element size at start-of-frame (0: 64, 1: 128, 2 or 3: 256 bytes). A declared length above that size sets the length-error bit, and payload bytes at offsets at or above the size are not written.
- R8: A frame is discarded whole when its partition has no free element, or when the list would already hold 8 entries after this cycle's push and pop. A discarded frame causes no write and no entry, and it sets ovf_o, which then stays high until reset.
- R9: The full-element list holds up to 8 entries in arrival order; fl_pop_i while fl_valid_o removes the head.
- R10: A free strobe returns the named element to its partition from the next cycle on. In the cycle of the strobe the allocator still sees the old state.
- R11: Bytes with in_vld_i low are ignored, and so are bytes without start-of-frame that arrive outside an open frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | Byte is the first of a frame |
| in_data_i | input | 8 | Input byte |
| in_part_i | input | 1 | Target partition at start-of-frame |
| elem_sz_i | input | 2 | Element size code |
| free_i | input | 1 | Return an element to the pool |
| free_part_i | input | 1 | Partition of the returned element |
| free_idx_i | input | 3 | Number of the returned element |
| wr_en_o | output | 1 | Element write strobe |
| wr_part_o | output | 1 | Partition being written |
| wr_idx_o | output | 3 | Element being written |
| wr_addr_o | output | 8 | Byte offset within the element |
| wr_data_o | output | 8 | Byte written |
| fl_valid_o | output | 1 | List head is valid |
| fl_data_o | output | 51 | List head entry |
| fl_pop_i | input | 1 | Remove the list head |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two functions can fall into the same cycle. The first pair is closing a cut-short frame onto the list and claiming an element for the frame that cut it. The second pair is a free strobe and a claim in the same partition. The bench provokes the first pair with a partial frame sent while the list already holds seven entries, so the early push fills the list and the new frame must be dropped. It provokes the second pair by freeing an element in the start-of-frame cycle of a frame whose partition is exhausted. That frame must be dropped, and the next frame must receive the freed element. A behavioural model built on queues judges every cycle's write port, list head and overflow flag.

// File: rtl/rbw_pkg.sv
package rbw_pkg;

  localparam int NUM_PART = 2;

  typedef struct packed {
    logic        len_err;
    logic        priv;
    logic        rsv;
    logic [3:0]  ftype;
    logic [7:0]  len;
    logic [31:0] ext;
  } rbw_status_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LEN,
    S_EXT,
    S_PAY,
    S_VP,
    S_DISC
  } rbw_state_e;

endpackage

// File: rtl/rbw_alloc.sv
module rbw_alloc
  import rbw_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_i,
  input  logic             take_i,
  input  logic             free_i,
  input  logic             free_part_i,
  input  logic [IDX_W-1:0] free_idx_i,
  output logic             grant_o,
  output logic [IDX_W-1:0] idx_o
);

  logic [NUM_PART-1:0][ELEMS-1:0] avail_q;
  logic [ELEMS-1:0]               sel;

  for (genvar p = 0; p < NUM_PART; p++) begin : g_part
    logic [ELEMS-1:0] rel;
    logic [ELEMS-1:0] tk;
    assign rel = (free_i && free_part_i == 1'(p)) ? (ELEMS'(1) << free_idx_i) : '0;
    assign tk  = (take_i && part_i == 1'(p)) ? (ELEMS'(1) << idx_o) : '0;
    // claim wins over a same-cycle release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) avail_q[p] <= '1;
      else         avail_q[p] <= (avail_q[p] | rel) & ~tk;
    end
  end

  always_comb begin
    sel     = avail_q[part_i];
    grant_o = |sel;
    idx_o   = '0;
    for (int i = ELEMS - 1; i >= 0; i--) begin
      if (sel[i]) idx_o = IDX_W'(i);
    end
  end

  p_take_claims_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !avail_q[$past(part_i)][$past(idx_o)]);

endmodule

// File: rtl/rbw_fifo.sv
module rbw_fifo #(
  parameter int W     = 51,
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic                       valid_o,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic          do_pop;

  assign do_pop  = pop_i && (count_q != '0);
  assign valid_o = count_q != '0;
  assign data_o  = mem_q[rd_q];
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      count_q <= count_q + CW'(push_i) - CW'(do_pop);
    end
  end

  p_list_no_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CW'(DEPTH)) || do_pop);

endmodule

// File: rtl/rx_elem_writer.sv
module rx_elem_writer
  import rbw_pkg::*;
#(
  parameter int ELEMS    = 8,
  parameter int FL_DEPTH = 8,
  localparam int IDX_W   = $clog2(ELEMS),
  localparam int ENTRY_W = 1 + IDX_W + $bits(rbw_status_t)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_vld_i,
  input  logic               in_sof_i,
  input  logic [7:0]         in_data_i,
  input  logic               in_part_i,
  input  logic [1:0]         elem_sz_i,
  input  logic               free_i,
  input  logic               free_part_i,
  input  logic [IDX_W-1:0]   free_idx_i,
  output logic               wr_en_o,
  output logic               wr_part_o,
  output logic [IDX_W-1:0]   wr_idx_o,
  output logic [7:0]         wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               fl_valid_o,
  output logic [ENTRY_W-1:0] fl_data_o,
  input  logic               fl_pop_i,
  output logic               ovf_o
);

  localparam int CW  = $clog2(FL_DEPTH + 1);
  localparam int CW1 = CW + 1;

  rbw_state_e       state_q;
  logic [8:0]       cnt_q, sz_q, sz_sel;
  rbw_status_t      st_q, st_out;
  logic             part_q;
  logic [IDX_W-1:0] idx_q, gidx;
  logic             grant, ovf_q;
  logic             acc, sof, busy, early_push, done_push, push, pop_eff, room, take;
  logic [CW-1:0]    fl_count;
  logic [CW1-1:0]   cnt_after;

  always_comb begin
    case (elem_sz_i)
      2'd0:    sz_sel = 9'd64;
      2'd1:    sz_sel = 9'd128;
      default: sz_sel = 9'd256;
    endcase
  end

  assign acc        = in_vld_i;
  assign sof        = acc && in_sof_i;
  assign busy       = state_q inside {S_LEN, S_EXT, S_PAY, S_VP};
  assign early_push = sof && busy;
  assign done_push  = acc && !in_sof_i && state_q == S_VP && cnt_q == 9'd1;
  assign push       = early_push || done_push;
  assign pop_eff    = fl_pop_i && fl_valid_o;
  // list room counted after this cycle's push and pop
  assign cnt_after  = {1'b0, fl_count} + CW1'(push) - CW1'(pop_eff);
  assign room       = cnt_after < CW1'(FL_DEPTH);
  assign take       = sof && room && grant;

  always_comb begin
    st_out         = st_q;
    st_out.len_err = st_q.len_err | early_push;
  end

  rbw_alloc #(.ELEMS(ELEMS), .IDX_W(IDX_W)) u_alloc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .part_i      (in_part_i),
    .take_i      (take),
    .free_i      (free_i),
    .free_part_i (free_part_i),
    .free_idx_i  (free_idx_i),
    .grant_o     (grant),
    .idx_o       (gidx)
  );

  rbw_fifo #(.W(ENTRY_W), .DEPTH(FL_DEPTH)) u_list (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({part_q, idx_q, st_out}),
    .pop_i   (fl_pop_i),
    .valid_o (fl_valid_o),
    .data_o  (fl_data_o),
    .count_o (fl_count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sz_q    <= '0;
      st_q    <= '0;
      part_q  <= 1'b0;
      idx_q   <= '0;
      ovf_q   <= 1'b0;
    end else if (acc) begin
      if (in_sof_i) begin
        cnt_q <= '0;
        if (take) begin
          state_q    <= S_LEN;
          part_q     <= in_part_i;
          idx_q      <= gidx;
          sz_q       <= sz_sel;
          st_q       <= '0;
          st_q.ftype <= in_data_i[3:0];
          st_q.rsv   <= in_data_i[4];
          st_q.priv  <= in_data_i[5];
        end else begin
          state_q <= S_DISC;
          ovf_q   <= 1'b1;
        end
      end else begin
        case (state_q)
          S_LEN: begin
            st_q.len <= in_data_i;
            if ({1'b0, in_data_i} > sz_q) st_q.len_err <= 1'b1;
            cnt_q   <= '0;
            state_q <= S_EXT;
          end
          S_EXT: begin
            st_q.ext <= {st_q.ext[23:0], in_data_i};
            if (cnt_q == 9'd3) begin
              cnt_q   <= '0;
              state_q <= (st_q.len == 8'd0) ? S_VP : S_PAY;
            end else cnt_q <= cnt_q + 9'd1;
          end
          S_PAY: begin
            if (cnt_q == {1'b0, st_q.len} - 9'd1) begin
              cnt_q   <= '0;
              state_q <= S_VP;
            end else cnt_q <= cnt_q + 9'd1;
          end
          S_VP: begin
            if (cnt_q == 9'd1) begin
              cnt_q   <= '0;
              state_q <= S_IDLE;
            end else cnt_q <= cnt_q + 9'd1;
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o   = acc && !in_sof_i && state_q == S_PAY && cnt_q < sz_q;
  assign wr_part_o = part_q;
  assign wr_idx_o  = idx_q;
  assign wr_addr_o = cnt_q[7:0];
  assign wr_data_o = in_data_i;
  assign ovf_o     = ovf_q;

  p_ovf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_trunc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> {1'b0, wr_addr_o} < sz_q);

endmodule

// File: tb/rx_elem_writer_tb_top.sv
`timescale 1ns/1ps
module rx_elem_writer_tb_top;

  localparam int FLD = 8;
  localparam int EW  = 51;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vld, sof, part, frel, frel_part, pop;
  logic [7:0]    din;
  logic [1:0]    esz;
  logic [2:0]    frel_idx;
  logic          wr_en, wr_part, fl_valid, ovf;
  logic [2:0]    wr_idx;
  logic [7:0]    wr_addr, wr_data;
  logic [EW-1:0] fl_data;

  always #5 clk = ~clk;

  rx_elem_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_vld_i(vld), .in_sof_i(sof), .in_data_i(din),
    .in_part_i(part), .elem_sz_i(esz), .free_i(frel), .free_part_i(frel_part),
    .free_idx_i(frel_idx), .wr_en_o(wr_en), .wr_part_o(wr_part), .wr_idx_o(wr_idx),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .fl_valid_o(fl_valid), .fl_data_o(fl_data),
    .fl_pop_i(pop), .ovf_o(ovf)
  );

  // behavioural reference
  bit            mfree [2][8];
  logic [EW-1:0] mq [$];
  bit            movf, mact, mpart, mcr, mp, merr;
  int            mpos, midx, mlen, msz;
  logic [31:0]   mext;
  logic [3:0]    mtype;

  int    checks = 0, fails = 0;
  string cur_req = "R1";
  bit    auto_pop = 0;

  function automatic logic [EW-1:0] mk_entry(bit err);
    return {mpart, 3'(midx), err, mp, mcr, mtype, 8'(mlen), mext};
  endfunction

  task automatic compare();
    bit ew, bad;
    bad = 0;
    ew = mact && vld && !sof && mpos >= 6 && mpos < 6 + mlen && (mpos - 6) < msz;
    if (wr_en !== ew) begin
      bad = 1;
      $display("FAIL %s write strobe: act %b exp %b", cur_req, wr_en, ew);
    end else if (ew && (wr_addr !== 8'(mpos - 6) || wr_data !== din ||
                        wr_part !== mpart || wr_idx !== 3'(midx))) begin
      bad = 1;
      $display("FAIL %s write: act p%0d e%0d a%0d d%h exp p%0d e%0d a%0d d%h", cur_req,
               wr_part, wr_idx, wr_addr, wr_data, mpart, midx, mpos - 6, din);
    end
    if (fl_valid !== (mq.size() > 0)) begin
      bad = 1;
      $display("FAIL %s list valid: act %b exp %b", cur_req, fl_valid, mq.size() > 0);
    end else if (mq.size() > 0 && fl_data !== mq[0]) begin
      bad = 1;
      $display("FAIL %s list entry: act %h exp %h", cur_req, fl_data, mq[0]);
    end
    if (ovf !== movf) begin
      bad = 1;
      $display("FAIL %s overflow: act %b exp %b", cur_req, ovf, movf);
    end
    checks++;
    if (bad) fails++;
  endtask

  task automatic model_update();
    int k, ak;
    k = -1;
    ak = -1;
    if (vld && sof)
      for (int i = 7; i >= 0; i--) if (mfree[part][i]) k = i;
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (vld) begin
      if (sof) begin
        if (mact) begin
          mq.push_back(mk_entry(1'b1));
          mact = 0;
        end
        if (k >= 0 && mq.size() < FLD) begin
          mact = 1; mpart = part; midx = k; ak = k;
          mtype = din[3:0]; mcr = din[4]; mp = din[5];
          msz = (esz == 2'd0) ? 64 : (esz == 2'd1) ? 128 : 256;
          merr = 0; mlen = 0; mext = '0; mpos = 1;
        end else movf = 1;
      end else if (mact) begin
        if (mpos == 1) begin
          mlen = int'(din);
          merr = mlen > msz;
        end else if (mpos <= 5) mext = {mext[23:0], din};
        if (mpos >= 7 && mpos == mlen + 7) begin
          mq.push_back(mk_entry(merr));
          mact = 0;
        end
        mpos++;
      end
    end
    if (frel) mfree[frel_part][frel_idx] = 1;
    if (ak >= 0) mfree[mpart][ak] = 0;
  endtask

  task automatic step();
    if (auto_pop) pop = (mq.size() > 0);
    @(negedge clk);
    compare();
    model_update();
    @(posedge clk);
    #1;
    vld = 0; sof = 0; din = '0; frel = 0; pop = 0;
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic send_frame(bit fp, logic [7:0] b0, int len, logic [31:0] ext,
                            logic [1:0] sz, int nbytes, int gap);
    logic [7:0] bq [$];
    bq.push_back(b0);
    bq.push_back(8'(len));
    for (int i = 3; i >= 0; i--) bq.push_back(ext[i*8 +: 8]);
    for (int i = 0; i < len; i++) bq.push_back(8'(i * 3 + int'(b0)));
    bq.push_back(8'hA5);
    bq.push_back(8'h5A);
    if (nbytes >= 0) while (bq.size() > nbytes) void'(bq.pop_back());
    foreach (bq[i]) begin
      vld = 1; sof = (i == 0); din = bq[i]; part = fp; esz = sz;
      step();
      repeat (gap) step();
    end
  endtask

  task automatic free_all();
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++) begin
        frel = 1; frel_part = p[0]; frel_idx = 3'(i);
        step();
      end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vld = 0; sof = 0; din = 0; part = 0; esz = 0; frel = 0; frel_part = 0;
    frel_idx = 0; pop = 0; rst_n = 0;
    for (int p = 0; p < 2; p++) for (int i = 0; i < 8; i++) mfree[p][i] = 1;
    movf = 0; mact = 0; mpos = 0; midx = 0; mlen = 0; msz = 64; mpart = 0;
    mext = '0; mtype = '0; mcr = 0; mp = 0; merr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R1 reset state
    if (wr_en !== 1'b0 || fl_valid !== 1'b0 || ovf !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: act %b%b%b exp 000", wr_en, fl_valid, ovf);
    end
    rst_n = 1;
    @(posedge clk);
    #1;
    cur_req = "R1"; idle(3);

    cur_req = "R3"; send_frame(0, 8'h35, 5, 32'hDEADBEEF, 2'd0, -1, 0); idle(2);
    cur_req = "R5"; auto_pop = 1; idle(2);
    cur_req = "R2"; send_frame(1, 8'h17, 3, 32'h01020304, 2'd1, -1, 0);
    send_frame(0, 8'h02, 4, 32'h0A0B0C0D, 2'd0, -1, 0); idle(2);
    cur_req = "R11"; send_frame(0, 8'h09, 6, 32'h11223344, 2'd2, -1, 1);
    vld = 1; din = 8'h77; step(); vld = 1; din = 8'h78; step(); idle(2);
    cur_req = "R4"; send_frame(1, 8'h21, 0, 32'hCAFEF00D, 2'd0, -1, 0); idle(2);
    cur_req = "R7"; send_frame(0, 8'h04, 100, 32'h55667788, 2'd0, -1, 0);
    send_frame(1, 8'h05, 200, 32'h99AABBCC, 2'd1, -1, 0);
    send_frame(0, 8'h06, 255, 32'h12345678, 2'd3, -1, 0); idle(2);
    cur_req = "R6"; send_frame(0, 8'h3F, 20, 32'hFEEDFACE, 2'd0, 10, 0);
    send_frame(1, 8'h08, 2, 32'h0BADC0DE, 2'd0, -1, 0); idle(2);
    cur_req = "R10"; free_all(); idle(2);

    cur_req = "R8";
    for (int n = 0; n < 8; n++) send_frame(0, 8'(n), 2, 32'(n), 2'd0, -1, 0);
    send_frame(0, 8'h0E, 3, 32'hAAAA5555, 2'd0, -1, 0);
    frel = 1; frel_part = 0; frel_idx = 3'd3;
    cur_req = "R10"; send_frame(0, 8'h0F, 3, 32'h5555AAAA, 2'd0, -1, 0);
    send_frame(0, 8'h1F, 3, 32'h13579BDF, 2'd0, -1, 0); idle(2);

    cur_req = "R9"; free_all(); auto_pop = 0;
    for (int n = 0; n < 8; n++) send_frame(n[0], 8'(n + 16), 1, 32'(n * 5), 2'd0, -1, 0);
    send_frame(1, 8'h2A, 2, 32'h0, 2'd0, -1, 0);
    auto_pop = 1; idle(12);

    cur_req = "R6"; free_all(); auto_pop = 0;
    for (int n = 0; n < 7; n++) send_frame(0, 8'(n + 32), 1, 32'(n), 2'd0, -1, 0);
    send_frame(1, 8'h2B, 8, 32'hA1B2C3D4, 2'd0, 9, 0);
    send_frame(1, 8'h2C, 2, 32'hE5F60718, 2'd0, -1, 0);
    auto_pop = 1; idle(12);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule